// File: doc/BRIEF.md
# Self-Timed Program Cycle Controller

This block sits behind the serial front end of a small nonvolatile word store. The front end hands it one fully decoded instruction at a time. It also reports each rising edge of the serial clock and each start bit it decodes. The controller holds a write-enable latch and owns the storage array. It starts a self-timed programming cycle when the chip-select line drops at the correct moment. For the length of that cycle it freezes the array and rejects new instructions.

The cycle length is a parameter counted in system clocks. The default stands in for a 10 ms worst-case cycle, and a bench can shrink it to a few dozen clocks. Status is presented as a drive-enable plus a level for the shared data output. A low level means the cycle is still running. A high level means the cycle is complete, and it stays on the line until the next start bit or until select falls. Array reads through the read port are never gated.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: After reset the enable latch is cleared, `busy` is 0, `q_oe` is 0 and every word of the array reads all ones.
- R2: A program instruction (WRITE, ERASE, fill-ones, fill-data) accepted while the enable latch is clear is dropped: `busy` never rises and no word changes.
- R3: Opcode 00 with top two address bits 11 sets the enable latch, and with 00 clears it. The latch stays set across any number of cycles until cleared or reset, and it changes only on an accepted instruction.
- R4: WRITE (opcode 01) replaces the addressed word with the supplied data whatever its previous value, with no erase instruction needed before it.
- R5: ERASE (opcode 11) sets the addressed word to all ones and leaves other words unchanged.
- R6: Opcode 00 with top bits 10 sets every word to all ones. With top bits 01 it writes the supplied data into every word.
- R7: A cycle starts only if select falls after the instruction is accepted and before any further serial-clock rise. If a serial-clock rise comes first, the instruction is discarded.
- R8: `busy` rises on the clock after the clock that samples select low, and it stays high for exactly `CYCLE_CLKS` clocks.
- R9: While `busy` is high and select is high, `q_oe`=1 and `q_out`=0, and any instruction presented is ignored.
- R10: When a cycle has finished and select is high, `q_oe`=1 and `q_out`=1. This lasts until `start_seen` pulses or select falls, after which `q_oe` is 0.
- R11: The read port returns array contents whatever the enable state. During a cycle it shows the old contents, and the update becomes visible on the clock where `busy` falls. READ (opcode 10) starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sel | input | 1 | Chip-select level, already synchronized |
| sclk_rise | input | 1 | One-clock pulse per serial-clock rising edge |
| start_seen | input | 1 | One-clock pulse when a start bit is decoded |
| cmd_valid | input | 1 | One-clock pulse: a complete instruction is present |
| cmd_op | input | 2 | Instruction opcode |
| cmd_addr | input | ADDR_W | Instruction address; top two bits select the special command |
| cmd_data | input | DATA_W | Instruction data |
| rd_addr | input | ADDR_W | Read-port address |
| rd_data | output | DATA_W | Read-port data |
| busy | output | 1 | Programming cycle in progress |
| q_oe | output | 1 | Status drive enable for the data output |
| q_out | output | 1 | Status level: 0 busy, 1 ready |

## Verification
A stuck or wrongly cleared enable latch shows on the next program instruction. In that case `busy` either rises when it should not, or fails to rise, on the clock after select falls. An off-by-one in the cycle timer shows as a `busy` pulse one clock too long or too short, which is measured against `CYCLE_CLKS`. A commit at the wrong time or to the wrong words appears on the read port on the clock where `busy` falls. A status flag that clears too early or too late shows on `q_oe` within one clock of the cycle ending, the start pulse, or the select edge.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        OPC_SPECIAL = 2'b00,
        OPC_WRITE   = 2'b01,
        OPC_READ    = 2'b10,
        OPC_ERASE   = 2'b11
    } pcc_opc_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_WEN_ON,
        ACT_WEN_OFF,
        ACT_WRITE,
        ACT_ERASE,
        ACT_FILL_ONES,
        ACT_FILL_DATA
    } pcc_act_e;

    typedef struct packed {
        logic busy;
        logic stat_en;
    } pcc_stat_t;

    function automatic pcc_act_e pcc_classify(input logic [1:0] op, input logic [1:0] sub);
        pcc_act_e a;
        case (op)
            OPC_WRITE: a = ACT_WRITE;
            OPC_ERASE: a = ACT_ERASE;
            OPC_READ:  a = ACT_NONE;
            default: begin
                case (sub)
                    2'b11:   a = ACT_WEN_ON;
                    2'b00:   a = ACT_WEN_OFF;
                    2'b10:   a = ACT_FILL_ONES;
                    default: a = ACT_FILL_DATA;
                endcase
            end
        endcase
        return a;
    endfunction

    function automatic logic pcc_is_program(input pcc_act_e a);
        return (a == ACT_WRITE) || (a == ACT_ERASE) ||
               (a == ACT_FILL_ONES) || (a == ACT_FILL_DATA);
    endfunction

endpackage

// File: rtl/pcc_sequencer.sv
module pcc_sequencer
    import pcc_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sclk_rise,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              busy,
    output logic              launch,
    output logic              sel_fall,
    output logic              wen,
    output pcc_act_e          job_act,
    output logic [ADDR_W-1:0] job_addr,
    output logic [DATA_W-1:0] job_data
);

    logic     sel_q;
    logic     armed_q;
    logic     wen_q;
    logic     accept;
    pcc_act_e new_act;

    assign sel_fall = sel_q & ~sel;
    assign accept   = cmd_valid & sel & ~busy;
    assign new_act  = pcc_classify(cmd_op, cmd_addr[ADDR_W-1 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            armed_q  <= 1'b0;
            wen_q    <= 1'b0;
            job_act  <= ACT_NONE;
            job_addr <= '0;
            job_data <= '0;
        end else begin
            sel_q <= sel;
            if (accept) begin
                case (new_act)
                    ACT_WEN_ON:  wen_q <= 1'b1;
                    ACT_WEN_OFF: wen_q <= 1'b0;
                    default:     wen_q <= wen_q;
                endcase
                armed_q  <= pcc_is_program(new_act);
                job_act  <= new_act;
                job_addr <= cmd_addr;
                job_data <= cmd_data;
            end else if (armed_q && (sclk_rise || sel_fall)) begin
                armed_q <= 1'b0;
            end
        end
    end

    assign launch = armed_q & sel_fall & ~sclk_rise & wen_q & ~busy;
    assign wen    = wen_q;

    AST_WEN_CMD_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(wen_q) |-> $past(cmd_valid)) else $error("wen changed without instruction"); // R3

    AST_NO_LAUNCH_AFTER_CLK: assert property (@(posedge clk) disable iff (rst)
        (armed_q && sclk_rise && !accept) |=> !launch) else $error("late launch"); // R7

endmodule

// File: rtl/pcc_timer.sv
module pcc_timer #(
    parameter int CYCLE_CLKS = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic done
);

    localparam int CYC_W = $clog2(CYCLE_CLKS + 1);
    localparam logic [CYC_W-1:0] LOAD_VAL = CYC_W'(CYCLE_CLKS - 1);

    logic [CYC_W-1:0] cnt_q;
    logic             busy_q;

    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (launch && !busy_q) begin
            cnt_q  <= LOAD_VAL;
            busy_q <= 1'b1;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= LOAD_VAL)) else $error("timer overrun"); // R8

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(launch)) else $error("busy without launch"); // R8

endmodule

// File: rtl/pcc_array.sv
module pcc_array
    import pcc_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  pcc_act_e          act,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH*DATA_W-1:0] flat;

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic              hit;

        assign hit = (addr == ADDR_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '1;
            end else if (commit) begin
                case (act)
                    ACT_WRITE:     if (hit) word_q <= data;
                    ACT_ERASE:     if (hit) word_q <= '1;
                    ACT_FILL_ONES: word_q <= '1;
                    ACT_FILL_DATA: word_q <= data;
                    default:       word_q <= word_q;
                endcase
            end
        end

        assign flat[w*DATA_W +: DATA_W] = word_q;
    end

    assign rd_data = flat[rd_addr*DATA_W +: DATA_W];

endmodule

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl
    import pcc_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 16,
    parameter int CYCLE_CLKS = 2_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sclk_rise,
    input  logic              start_seen,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              q_oe,
    output logic              q_out
);

    logic              launch;
    logic              sel_fall;
    logic              wen;
    logic              done;
    pcc_act_e          job_act;
    logic [ADDR_W-1:0] job_addr;
    logic [DATA_W-1:0] job_data;
    pcc_stat_t         stat;

    pcc_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .busy      (stat.busy),
        .launch    (launch),
        .sel_fall  (sel_fall),
        .wen       (wen),
        .job_act   (job_act),
        .job_addr  (job_addr),
        .job_data  (job_data)
    );

    pcc_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (stat.busy),
        .done   (done)
    );

    pcc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .commit  (done),
        .act     (job_act),
        .addr    (job_addr),
        .data    (job_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat.stat_en <= 1'b0;
        end else if (launch) begin
            stat.stat_en <= 1'b1;
        end else if (!stat.busy && (start_seen || sel_fall)) begin
            stat.stat_en <= 1'b0;
        end
    end

    assign busy  = stat.busy;
    assign q_oe  = sel & stat.stat_en;
    assign q_out = ~stat.busy;

    AST_BUSY_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wen)) else $error("cycle while disabled"); // R2

    AST_READY_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && sel) |-> (q_oe && q_out)) else $error("no ready level"); // R10

    AST_ARRAY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $stable(rd_addr)) |-> $stable(rd_data)) else $error("array moved mid-cycle"); // R11

endmodule

// File: tb/prog_cycle_ctrl_tb.sv
module prog_cycle_ctrl_tb;

    localparam int AW  = 7;
    localparam int DW  = 16;
    localparam int CYC = 40;
    localparam int DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          sclk_rise = 1'b0;
    logic          start_seen = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy, q_oe, q_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    prog_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(CYC)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .sclk_rise(sclk_rise),
        .start_seen(start_seen), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .q_oe(q_oe), .q_out(q_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic word_is(input string req, input int a, input logic [DW-1:0] exp);
        rd_addr = AW'(a);
        #1;
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    task automatic all_are(input string req, input logic [DW-1:0] exp);
        int bad = 0;
        for (int a = 0; a < DEP; a++) begin
            rd_addr = AW'(a);
            #1;
            if (rd_data !== exp) bad++;
        end
        chk(req, 32'(bad), 32'd0);
    endtask

    // Sends one instruction; returns on the negedge where busy is first visible.
    task automatic send(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit late_clk);
        @(negedge clk) sel = 1'b1;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; end
        @(negedge clk) cmd_valid = 1'b0;
        if (late_clk) begin
            sclk_rise = 1'b1;
            @(negedge clk) sclk_rise = 1'b0;
        end
        @(negedge clk) sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy === 1'b1 && n < 4 * CYC) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 busy", 32'(busy), 0);
        chk("R1 q_oe", 32'(q_oe), 0);
        all_are("R1 array ones", '1);
    endtask

    task automatic t_disabled_write;
        int n;
        send(2'b01, 7'd5, 16'h1234, 0);
        busy_len(n);
        chk("R2 no cycle", 32'(n), 0);
        word_is("R2 word kept", 5, 16'hFFFF);
    endtask

    task automatic t_write;
        int n;
        send(2'b00, 7'b1100000, '0, 0);
        send(2'b01, 7'd5, 16'h1234, 0);
        busy_len(n);
        chk("R8 busy length", 32'(n), CYC);
        word_is("R4 written", 5, 16'h1234);
        send(2'b01, 7'd5, 16'h00FF, 0);
        busy_len(n);
        word_is("R4 overwrite no erase", 5, 16'h00FF);
        send(2'b01, 7'd9, 16'hA5A5, 0);
        busy_len(n);
        chk("R3 enable persists", 32'(n), CYC);
        word_is("R3 third write", 9, 16'hA5A5);
    endtask

    task automatic t_erase;
        int n;
        send(2'b11, 7'd5, '0, 0);
        busy_len(n);
        word_is("R5 erased", 5, 16'hFFFF);
        word_is("R5 neighbour kept", 9, 16'hA5A5);
    endtask

    task automatic t_late;
        int n;
        send(2'b01, 7'd20, 16'h7777, 1);
        busy_len(n);
        chk("R7 late select no cycle", 32'(n), 0);
        word_is("R7 word kept", 20, 16'hFFFF);
    endtask

    task automatic t_status;
        int n;
        send(2'b01, 7'd30, 16'h0F0F, 0);
        @(negedge clk) sel = 1'b1;
        #1;
        chk("R9 q_oe busy", 32'(q_oe), 1);
        chk("R9 q_out busy", 32'(q_out), 0);
        word_is("R11 old data mid-cycle", 30, 16'hFFFF);
        @(negedge clk) begin cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 7'd31; cmd_data = 16'hDEAD; end
        @(negedge clk) cmd_valid = 1'b0;
        busy_len(n);
        #1;
        chk("R10 ready drive", 32'(q_oe), 1);
        chk("R10 ready level", 32'(q_out), 1);
        repeat (3) @(negedge clk);
        chk("R10 ready holds", 32'({q_oe, q_out}), 3);
        start_seen = 1'b1;
        @(negedge clk) start_seen = 1'b0;
        chk("R10 start clears", 32'(q_oe), 0);
        sel = 1'b0;
        word_is("R9 busy command ignored", 31, 16'hFFFF);
        word_is("R4 status write", 30, 16'h0F0F);
        send(2'b01, 7'd40, 16'h1111, 0);
        busy_len(n);
        sel = 1'b1;
        #1;
        chk("R10 ready after low select", 32'({q_oe, q_out}), 3);
        @(negedge clk) sel = 1'b0;
        @(negedge clk) sel = 1'b1;
        #1;
        chk("R10 select fall clears", 32'(q_oe), 0);
        @(negedge clk) sel = 1'b0;
    endtask

    task automatic t_bulk;
        int n;
        send(2'b00, 7'b0100000, 16'h5A5A, 0);
        busy_len(n);
        all_are("R6 fill data", 16'h5A5A);
        send(2'b00, 7'b1000000, '0, 0);
        busy_len(n);
        all_are("R6 fill ones", 16'hFFFF);
    endtask

    task automatic t_disable_read;
        int n;
        send(2'b01, 7'd3, 16'hBEEF, 0);
        busy_len(n);
        send(2'b00, 7'b0011111, '0, 0);
        send(2'b11, 7'd3, '0, 0);
        busy_len(n);
        chk("R3 disabled no cycle", 32'(n), 0);
        word_is("R11 read while disabled", 3, 16'hBEEF);
        send(2'b10, 7'd3, '0, 0);
        busy_len(n);
        chk("R11 read starts no cycle", 32'(n), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled_write();
        t_write();
        t_erase();
        t_late();
        t_status();
        t_bulk();
        t_disable_read();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule